// File: doc/BRIEF.md
# Voted Configuration Register With Serial Test Port

This block keeps the configuration of a multi-channel optical link chip in one 16-bit command word. In normal operation the word comes from three redundant command decoders. Each decoder presents its own copy with a strobe. The block stores the bitwise two-of-three majority of the copies, so a single corrupted decoder cannot change the configuration. In test mode the decoders are ignored and the word is shifted in through a three-wire serial port instead. That port also shifts the currently stored word back out, so the contents can be checked.

Each stored word is decoded at once. The top nibble selects a destination and the low byte carries the value. The destinations are the per-channel laser drive-level codes and the select fields that steer receive or transmit traffic to a spare lane. After reset every drive-level code is set to a nominal value, so the link works even if no command ever arrives. The serial inputs are sampled in the system clock domain, and each edge of the serial clock is detected by comparing it with its previous sample.

Top module: `cfg_vote_reg`

## Requirements
- R1: After synchronous reset, every channel drive-level code is 213 (8'hD5), both steering selects are 0, the stored word is 0 and `tp_dout` is 0.
- R2: With `mode_tp` low and at least two bits of `dec_vld` high at a clock edge, the stored word becomes the bitwise majority of `dec_word_a`, `dec_word_b` and `dec_word_c`, and its decoded outputs change at that same edge.
- R3: With `mode_tp` low and fewer than two bits of `dec_vld` high, no output changes.
- R4: Word format: bits [15:12] are the target and bits [7:0] the value. Target n (0 to NUM_CH-1) loads channel n's code, which is `dac_codes[n*8 +: 8]`, with the value.
- R5: Target 4 loads `rx_sel` with value bits [3:0]. Target 5 loads `tx_sel` with value bits [3:0].
- R6: Targets 6 to 15 change no drive-level code and no select, but the word is still stored and read back.
- R7: With `mode_tp` high, decoder strobes have no effect.
- R8: A clock edge at which `tp_en` is high and `tp_clk` has risen (sampled 1 now and 0 at the previous edge) shifts `tp_din` in, MSB first. At the first edge where `tp_en` is sampled low after being high, the shifted word is stored and decoded if `mode_tp` is high and exactly 16 bits were shifted.
- R9: A serial load of any length other than 16 bits is discarded.
- R10: While `tp_en` is low, `tp_dout` shows bit 15 of the stored word from the second edge after it is stored onward. While `tp_en` is high, each serial clock rise shifts the readback left, so before the k-th rise `tp_dout` equals stored-word bit 15-k.
- R11: With `mode_tp` low, a complete 16-bit serial load changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tp | input | 1 | 0: decoder vote loads, 1: serial port loads |
| dec_word_a | input | 16 | Command word from decoder A |
| dec_word_b | input | 16 | Command word from decoder B |
| dec_word_c | input | 16 | Command word from decoder C |
| dec_vld | input | 3 | Per-decoder valid strobes (bit 0 = A) |
| tp_clk | input | 1 | Serial test clock, sampled by clk |
| tp_en | input | 1 | Serial test enable, framing one load |
| tp_din | input | 1 | Serial test data in |
| dac_codes | output | NUM_CH*8 | Drive-level codes, channel 0 in the low byte |
| rx_sel | output | 4 | Receive-side spare steering select |
| tx_sel | output | 4 | Transmit-side spare steering select |
| tp_dout | output | 1 | Serial readback of the stored word |

## Verification
Two things share the serial clock rises: shifting a new word in and shifting the old stored word out. The bench checks `tp_dout` before every rise against the word that was stored before the load began. The new word is not allowed to take effect until the enable drops. Random vote rounds vary the strobe patterns, the bit disagreements between the decoders and the targets. Directed cases cover frames of 15 and 17 bits, serial loads made in decoder mode, and decoder strobes given in test mode. After each of these the outputs are compared with a model in the bench.

// File: rtl/cfgv_pkg.sv
package cfgv_pkg;
  localparam int CFG_W   = 16;
  localparam int TGT_W   = 4;
  localparam int TGT_LSB = 12;
  localparam int VAL_W   = 8;

  localparam logic [TGT_W-1:0] TGT_RX = 4'd4;
  localparam logic [TGT_W-1:0] TGT_TX = 4'd5;

  typedef logic [CFG_W-1:0] cfg_word_t;

  function automatic cfg_word_t maj3(cfg_word_t a, cfg_word_t b, cfg_word_t c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cfgv_vote.sv
module cfgv_vote
  import cfgv_pkg::*;
(
  input  cfg_word_t   w_a,
  input  cfg_word_t   w_b,
  input  cfg_word_t   w_c,
  input  logic [2:0]  vld,
  output logic        hit,
  output cfg_word_t   word
);
  always_comb begin
    hit  = (vld[0] & vld[1]) | (vld[0] & vld[2]) | (vld[1] & vld[2]);
    word = maj3(w_a, w_b, w_c);
  end
endmodule

// File: rtl/cfgv_tport.sv
module cfgv_tport
  import cfgv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_tp,
  input  logic      tp_clk,
  input  logic      tp_en,
  input  logic      tp_din,
  input  cfg_word_t active,
  output logic      commit,
  output cfg_word_t word,
  output logic      tp_dout
);
  localparam int CNT_W = $clog2(CFG_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CFG_W + 1);

  logic             clk_q, en_q;
  logic [CNT_W-1:0] cnt;
  cfg_word_t        sr, rb;
  logic             rise;

  assign rise    = tp_clk & ~clk_q;
  assign commit  = en_q & ~tp_en & mode_tp & (cnt == CNT_FULL);
  assign word    = sr;
  assign tp_dout = rb[CFG_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
      rb    <= '0;
    end else begin
      clk_q <= tp_clk;
      en_q  <= tp_en;
      if (tp_en) begin
        if (rise) begin
          sr <= {sr[CFG_W-2:0], tp_din};
          rb <= {rb[CFG_W-2:0], 1'b0};
          if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
        rb  <= active;
      end
    end
  end
endmodule

// File: rtl/cfgv_decode.sv
module cfgv_decode
  import cfgv_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 8,
  parameter int STEER_W  = 4,
  parameter int DEF_CODE = 213
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  cfg_word_t                word,
  output logic [NUM_CH*CODE_W-1:0] dac_codes,
  output logic [STEER_W-1:0]       rx_sel,
  output logic [STEER_W-1:0]       tx_sel,
  output cfg_word_t                active
);
  logic [TGT_W-1:0] tgt;
  assign tgt = word[TGT_LSB +: TGT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) dac_codes[c*CODE_W +: CODE_W] <= CODE_W'(DEF_CODE);
      rx_sel <= '0;
      tx_sel <= '0;
      active <= '0;
    end else if (load) begin
      active <= word;
      for (int c = 0; c < NUM_CH; c++)
        if (tgt == TGT_W'(c)) dac_codes[c*CODE_W +: CODE_W] <= word[CODE_W-1:0];
      if (tgt == TGT_RX) rx_sel <= word[STEER_W-1:0];
      if (tgt == TGT_TX) tx_sel <= word[STEER_W-1:0];
    end
  end
endmodule

// File: rtl/cfg_vote_reg.sv
module cfg_vote_reg
  import cfgv_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 8,
  parameter int STEER_W  = 4,
  parameter int DEF_CODE = 213
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_tp,
  input  logic [CFG_W-1:0]         dec_word_a,
  input  logic [CFG_W-1:0]         dec_word_b,
  input  logic [CFG_W-1:0]         dec_word_c,
  input  logic [2:0]               dec_vld,
  input  logic                     tp_clk,
  input  logic                     tp_en,
  input  logic                     tp_din,
  output logic [NUM_CH*CODE_W-1:0] dac_codes,
  output logic [STEER_W-1:0]       rx_sel,
  output logic [STEER_W-1:0]       tx_sel,
  output logic                     tp_dout
);
  logic      vote_hit, tp_commit, load;
  cfg_word_t vote_word, tp_word, ld_word, active;

  cfgv_vote u_vote (
    .w_a(dec_word_a), .w_b(dec_word_b), .w_c(dec_word_c),
    .vld(dec_vld), .hit(vote_hit), .word(vote_word)
  );

  cfgv_tport u_tport (
    .clk(clk), .rst(rst), .mode_tp(mode_tp), .tp_clk(tp_clk), .tp_en(tp_en),
    .tp_din(tp_din), .active(active), .commit(tp_commit), .word(tp_word),
    .tp_dout(tp_dout)
  );

  assign load    = mode_tp ? tp_commit : vote_hit;
  assign ld_word = mode_tp ? tp_word : vote_word;

  cfgv_decode #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .STEER_W(STEER_W), .DEF_CODE(DEF_CODE)
  ) u_decode (
    .clk(clk), .rst(rst), .load(load), .word(ld_word),
    .dac_codes(dac_codes), .rx_sel(rx_sel), .tx_sel(tx_sel), .active(active)
  );
endmodule

// File: rtl/cfg_vote_reg_chk.sv
module cfg_vote_reg_chk
  import cfgv_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 8,
  parameter int STEER_W  = 4,
  parameter int DEF_CODE = 213
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mode_tp,
  input logic [CFG_W-1:0]         dec_word_a,
  input logic [CFG_W-1:0]         dec_word_b,
  input logic [CFG_W-1:0]         dec_word_c,
  input logic [2:0]               dec_vld,
  input logic                     tp_en,
  input logic [NUM_CH*CODE_W-1:0] dac_codes,
  input logic [STEER_W-1:0]       rx_sel,
  input logic [STEER_W-1:0]       tx_sel
);
  cfg_word_t m;
  assign m = maj3(dec_word_a, dec_word_b, dec_word_c);

  p_reset_default_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dac_codes == {NUM_CH{CODE_W'(DEF_CODE)}}) && rx_sel == '0 && tx_sel == '0);

  p_vote_ch0_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode_tp && $countones(dec_vld) >= 2 && m[15:12] == 4'd0)
      |=> dac_codes[CODE_W-1:0] == $past(m[CODE_W-1:0]));

  p_few_strobes_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_tp && $countones(dec_vld) < 2)
      |=> $stable(dac_codes) && $stable(rx_sel) && $stable(tx_sel));

  p_tx_steer_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_tp && $countones(dec_vld) >= 2 && m[15:12] == 4'd5)
      |=> tx_sel == $past(m[STEER_W-1:0]));

  p_other_target_r6: assert property (@(posedge clk) disable iff (rst)
    (!mode_tp && $countones(dec_vld) >= 2 && m[15:12] > 4'd5)
      |=> $stable(dac_codes) && $stable(rx_sel) && $stable(tx_sel));

  p_test_mode_shift_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_tp && tp_en) |=> $stable(dac_codes) && $stable(rx_sel) && $stable(tx_sel));
endmodule

bind cfg_vote_reg cfg_vote_reg_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .STEER_W(STEER_W), .DEF_CODE(DEF_CODE)
) u_chk (
  .clk(clk), .rst(rst), .mode_tp(mode_tp), .dec_word_a(dec_word_a),
  .dec_word_b(dec_word_b), .dec_word_c(dec_word_c), .dec_vld(dec_vld),
  .tp_en(tp_en), .dac_codes(dac_codes), .rx_sel(rx_sel), .tx_sel(tx_sel)
);

// File: tb/test_cfg_vote_reg.sv
module test_cfg_vote_reg;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_tp = 1'b0;
  logic [15:0] wa = '0, wb = '0, wc = '0;
  logic [2:0]  vld = '0;
  logic        tp_clk = 1'b0, tp_en = 1'b0, tp_din = 1'b0;
  logic [NCH*8-1:0] dac_codes;
  logic [3:0]  rx_sel, tx_sel;
  logic        tp_dout;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  m_dac [NCH];
  logic [3:0]  m_rx, m_tx;
  logic [15:0] m_cfg;

  always #5 clk = ~clk;

  cfg_vote_reg i_cfg_vote_reg (
    .clk(clk), .rst(rst), .mode_tp(mode_tp), .dec_word_a(wa), .dec_word_b(wb),
    .dec_word_c(wc), .dec_vld(vld), .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din),
    .dac_codes(dac_codes), .rx_sel(rx_sel), .tx_sel(tx_sel), .tp_dout(tp_dout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vote(logic [15:0] a, logic [15:0] b, logic [15:0] c);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
    return r;
  endfunction

  function automatic void model_apply(logic [15:0] w);
    m_cfg = w;
    if (w[15:12] < NCH) m_dac[w[15:12]] = w[7:0];
    else if (w[15:12] == 4'd4) m_rx = w[3:0];
    else if (w[15:12] == 4'd5) m_tx = w[3:0];
  endfunction

  task automatic chk_out(input string req);
    for (int c = 0; c < NCH; c++) chk(req, 32'(dac_codes[c*8 +: 8]), 32'(m_dac[c]));
    chk(req, 32'(rx_sel), 32'(m_rx));
    chk(req, 32'(tx_sel), 32'(m_tx));
  endtask

  task automatic do_vote(input logic md, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [2:0] v, input string req);
    mode_tp = md; wa = a; wb = b; wc = c; vld = v;
    @(negedge clk);
    vld = '0;
    if (!md && $countones(v) >= 2) model_apply(vote(a, b, c));
    chk_out(req);
  endtask

  // Serial load of nb bits, MSB first; readback of the old word checked per rise (R10).
  task automatic tp_load(input logic md, input logic [16:0] w, input int nb, input string req);
    logic [15:0] old;
    mode_tp = md;
    repeat (2) @(negedge clk);
    old = m_cfg;
    chk("R10 idle readback", 32'(tp_dout), 32'(old[15]));
    tp_en = 1'b1;
    for (int i = 0; i < nb; i++) begin
      tp_clk = 1'b0; tp_din = w[nb-1-i];
      @(negedge clk);
      chk("R10 shift readback", 32'(tp_dout), (i < 16) ? 32'(old[15-i]) : 32'd0);
      tp_clk = 1'b1;
      @(negedge clk);
    end
    tp_clk = 1'b0; tp_en = 1'b0;
    if (nb > 0) chk_out("R8 no change before enable drops");
    @(negedge clk);
    if (md && nb == 16) model_apply(w[15:0]);
    chk_out(req);
  endtask

  function automatic logic [15:0] rand_word();
    logic [15:0] w = 16'($urandom);
    w[15:12] = 4'($urandom_range(0, 7));
    return w;
  endfunction

  initial begin : wdog
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) m_dac[c] = 8'd213;
    m_rx = '0; m_tx = '0; m_cfg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1 reset defaults");
    chk("R1 reset readback", 32'(tp_dout), 32'd0);

    // Directed: one disagreeing decoder is outvoted (R2, R4)
    do_vote(1'b0, 16'h0155, 16'h01AA, 16'h0155, 3'b111, "R2 R4 outvoted copy");
    do_vote(1'b0, 16'h2077, 16'h2077, 16'hFFFF, 3'b011, "R2 two strobes");
    do_vote(1'b0, 16'h3012, 16'h3012, 16'h3012, 3'b100, "R3 single strobe");
    do_vote(1'b0, 16'h409C, 16'h409C, 16'h409C, 3'b101, "R5 rx steering");
    do_vote(1'b0, 16'h5F0B, 16'h5F0B, 16'h5F0B, 3'b110, "R5 tx steering");
    do_vote(1'b0, 16'h9A33, 16'h9A33, 16'h9A33, 3'b111, "R6 unused target");
    tp_load(1'b0, 17'h1_2345, 16, "R11 serial ignored in decoder mode");
    do_vote(1'b1, 16'h0001, 16'h0001, 16'h0001, 3'b111, "R7 strobes in test mode");
    tp_load(1'b1, 17'h0_1042, 16, "R8 serial load ch1");
    tp_load(1'b1, 17'h0_0011, 15, "R9 short frame");
    tp_load(1'b1, 17'h1_3E3E, 17, "R9 long frame");
    tp_load(1'b1, 17'h0_C0DE, 16, "R8 R6 serial unused target");

    for (int it = 0; it < 80; it++) begin
      logic [15:0] base = rand_word();
      int kind = $urandom_range(0, 9);
      if (kind < 7)
        do_vote(kind == 6, base, base ^ 16'($urandom) & 16'($urandom), base,
                3'($urandom), "R2 R3 R7 random vote");
      else
        tp_load(1'($urandom), {1'b0, base}, (kind == 9) ? $urandom_range(14, 17) : 16,
                "R8 R9 R11 random serial");
    end
    tp_load(1'b0, 17'h0, 16, "R10 final readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule